// File: doc/BRIEF.md
# Configurable Macrocell Register

This block is the storage element of one programmable-logic macrocell. A static configuration word decides which of eight clock sources drives the flip-flop. It also picks one of four clock-enable sources. Finally, it sets whether the block-wide initialization term and two local product terms act as asynchronous set and reset, and in which roles.

The register's value after power-on depends on that configuration. A cell whose block initialization term acts as a set starts at 1. Every other cell starts at 0.

The configuration is expected to change only while the power-on reset is asserted. Switching the clock multiplexer at any other time can produce a spurious edge.

Configuration word layout (`cfg`):
- bits [2:0] select the clock.
- bits [4:3] select the clock enable.
- bit 5 enables set/reset.
- bit 6 swaps the set and reset roles.

Top module: `mc_reg_cell`

## Requirements
- R1: Clock select `cfg[2:0]` values 0 to 3 pick `blk_clk[0]` to `blk_clk[3]`. Value 4 picks `pt_clk`. Value 5 picks the inverse of `pt_clk`, so the register loads on a falling edge of `pt_clk`. Value 6 picks `shared_pt_clk`.
- R2: With clock select 7 (ground), no clock edge reaches the register. `q` changes only through an asynchronous set or reset.
- R3: Enable select `cfg[4:3]` value 0 uses `pt_ce`, 1 uses the inverse of `pt_ce`, 2 uses the level of `shared_pt_clk`, and 3 is always enabled.
- R4: On a selected clock edge with the enable low, `q` keeps its value whatever `d` is.
- R5: With `cfg[5]` = 0, `blk_init`, `sr_term0` and `sr_term1` have no effect on `q`.
- R6: With `cfg[5]` = 1 and `cfg[6]` = 0, `sr_term0` and `blk_init` reset `q` to 0, and `sr_term1` sets `q` to 1.
- R7: With `cfg[5]` = 1 and `cfg[6]` = 1, `sr_term0` and `blk_init` set `q` to 1, and `sr_term1` resets `q` to 0.
- R8: When a set and a reset are active together, `q` is 0.
- R9: While `por_n` is low, `q` is 1 if `cfg[5]` and `cfg[6]` are both 1, and 0 otherwise.
- R10: While `por_n` is low, the set/reset terms, clocks and data have no effect on `q`.
- R11: Set and reset act immediately, without a clock edge. While a set or reset is held, clock edges do not load `d`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| blk_clk | input | 4 | Block clocks |
| pt_clk | input | 1 | Product-term clock |
| shared_pt_clk | input | 1 | Shared product-term clock, also usable as an enable |
| pt_ce | input | 1 | Product-term initialization / clock-enable term |
| blk_init | input | 1 | Block-level initialization term |
| sr_term0 | input | 1 | Local set/reset product term 0 |
| sr_term1 | input | 1 | Local set/reset product term 1 |
| d | input | 1 | Data input |
| cfg | input | 7 | Static configuration word |
| q | output | 1 | Registered value |

## Verification
The hardest situation to reach is a register that holds a value its power-on state would never give it, and that then meets set/reset terms in the swapped roles or under a grounded clock.

The bench first loads the opposite value through a selected clock edge. It then drives each term for whole cycles, with no clock pulse, and reads `q` between edges. This shows that the term acted alone, and in which direction.

Each configuration change is made under `por_n` low. This avoids clock-mux glitches and also exercises the configuration-dependent power-on value.

// File: rtl/mc_pkg.sv
// Shared types and encodings for the macrocell register.
// Assumes the configuration word is static outside power-on reset.
package mc_pkg;
    localparam int NUM_BLK_CLK = 4;
    localparam int CLK_SEL_W   = $clog2(NUM_BLK_CLK + 4);
    localparam int CE_SEL_W    = 2;
    localparam int CFG_W       = CLK_SEL_W + CE_SEL_W + 2;

    typedef enum logic [CLK_SEL_W-1:0] {
        CK_BLK0 = 3'd0, CK_BLK1 = 3'd1, CK_BLK2 = 3'd2, CK_BLK3 = 3'd3,
        CK_PT   = 3'd4, CK_PT_N = 3'd5, CK_SHR  = 3'd6, CK_GND  = 3'd7
    } clk_sel_e;

    typedef enum logic [CE_SEL_W-1:0] {
        CE_PT = 2'd0, CE_PT_N = 2'd1, CE_SHR = 2'd2, CE_ONE = 2'd3
    } ce_sel_e;

    typedef struct packed {
        logic     swap;
        logic     sr_en;
        ce_sel_e  ce_sel;
        clk_sel_e clk_sel;
    } mc_cfg_t;
endpackage

// File: rtl/mc_clk_sel.sv
// Clock source multiplexer: picks a block clock, the product-term clock
// (true or inverted), the shared product-term clock, or a constant low.
// Assumes the select is only changed while the register is held in reset.
module mc_clk_sel
    import mc_pkg::*;
#(
    parameter int NBC = NUM_BLK_CLK
) (
    input  logic [NBC-1:0] blk_clk,
    input  logic           pt_clk,
    input  logic           shared_pt_clk,
    input  clk_sel_e       sel,
    output logic           clk_o
);
    localparam int IDX_W = $clog2(NBC);

    logic [NBC-1:0] blk_hit;

    // Decode which block clock, if any, is selected.
    for (genvar i = 0; i < NBC; i++) begin : g_blk
        assign blk_hit[i] = (sel == clk_sel_e'(i)) && blk_clk[i];
    end

    // Final source choice.
    always_comb begin
        unique case (sel)
            CK_PT:   clk_o = pt_clk;
            CK_PT_N: clk_o = ~pt_clk;
            CK_SHR:  clk_o = shared_pt_clk;
            CK_GND:  clk_o = 1'b0;
            default: clk_o = |blk_hit;
        endcase
    end

    logic [IDX_W-1:0] unused_idx;
    assign unused_idx = '0;
endmodule

// File: rtl/mc_ce_sel.sv
// Four-way clock-enable multiplexer.
// Assumes the select is static during operation.
module mc_ce_sel
    import mc_pkg::*;
(
    input  logic    pt_ce,
    input  logic    shared_pt_clk,
    input  ce_sel_e sel,
    output logic    ce_o
);
    // Pick the enable source.
    always_comb begin
        unique case (sel)
            CE_PT:   ce_o = pt_ce;
            CE_PT_N: ce_o = ~pt_ce;
            CE_SHR:  ce_o = shared_pt_clk;
            default: ce_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/mc_init_ctl.sv
// Set/reset steering: maps the block initialization term and the two local
// terms onto asynchronous set and clear, applies the swap option, gives
// clear priority, and forces the configuration-dependent power-on value.
// Assumes terms are glitch-free levels.
module mc_init_ctl
    import mc_pkg::*;
(
    input  logic    por_n,
    input  mc_cfg_t cfg,
    input  logic    blk_init,
    input  logic    sr_term0,
    input  logic    sr_term1,
    output logic    set_o,
    output logic    clr_o
);
    logic por_val;
    logic set_raw;
    logic clr_raw;

    // Power-on value: 1 only when the block term acts as a set.
    assign por_val = cfg.sr_en & cfg.swap;

    // Role mapping of the three terms.
    always_comb begin
        if (!cfg.sr_en) begin
            set_raw = 1'b0;
            clr_raw = 1'b0;
        end else if (cfg.swap) begin
            set_raw = sr_term0 | blk_init;
            clr_raw = sr_term1;
        end else begin
            set_raw = sr_term1;
            clr_raw = sr_term0 | blk_init;
        end
    end

    // Power-on override, then clear-over-set priority.
    always_comb begin
        if (!por_n) begin
            set_o = por_val;
            clr_o = ~por_val;
        end else begin
            clr_o = clr_raw;
            set_o = set_raw & ~clr_raw;
        end
    end

    // Set and clear never reach the flip-flop together.
    always_comb begin
        AST_SET_CLR_EXCL: assert (!(set_o && clr_o)); // R8
    end
endmodule

// File: rtl/mc_reg_cell.sv
// Configurable macrocell register: selected clock, selected enable,
// asynchronous set/reset with clear priority, configuration-dependent
// power-on value. Assumes cfg changes only while por_n is low.
module mc_reg_cell
    import mc_pkg::*;
(
    input  logic                   por_n,
    input  logic [NUM_BLK_CLK-1:0] blk_clk,
    input  logic                   pt_clk,
    input  logic                   shared_pt_clk,
    input  logic                   pt_ce,
    input  logic                   blk_init,
    input  logic                   sr_term0,
    input  logic                   sr_term1,
    input  logic                   d,
    input  logic [CFG_W-1:0]       cfg,
    output logic                   q
);
    mc_cfg_t cfg_s;
    logic    sel_clk;
    logic    ce;
    logic    set_a;
    logic    clr_a;

    assign cfg_s = mc_cfg_t'(cfg);

    mc_clk_sel #(.NBC(NUM_BLK_CLK)) u_clk (
        .blk_clk       (blk_clk),
        .pt_clk        (pt_clk),
        .shared_pt_clk (shared_pt_clk),
        .sel           (cfg_s.clk_sel),
        .clk_o         (sel_clk)
    );

    mc_ce_sel u_ce (
        .pt_ce         (pt_ce),
        .shared_pt_clk (shared_pt_clk),
        .sel           (cfg_s.ce_sel),
        .ce_o          (ce)
    );

    mc_init_ctl u_init (
        .por_n    (por_n),
        .cfg      (cfg_s),
        .blk_init (blk_init),
        .sr_term0 (sr_term0),
        .sr_term1 (sr_term1),
        .set_o    (set_a),
        .clr_o    (clr_a)
    );

    // Storage flip-flop with asynchronous clear (priority) and set.
    always_ff @(posedge sel_clk or posedge clr_a or posedge set_a) begin
        if (clr_a)      q <= 1'b0;
        else if (set_a) q <= 1'b1;
        else if (ce)    q <= d;
    end

    // Checks sampled on block clock 0.
    AST_POR_VALUE: assert property (@(posedge blk_clk[0])
        !por_n |-> (q == (cfg_s.sr_en && cfg_s.swap))); // R9
    AST_CLR_FORCES_ZERO: assert property (@(posedge blk_clk[0]) disable iff (!por_n)
        clr_a |-> !q); // R8
    AST_SET_FORCES_ONE: assert property (@(posedge blk_clk[0]) disable iff (!por_n)
        (set_a && !clr_a) |-> q); // R11
    AST_GND_HOLD: assert property (@(posedge blk_clk[0]) disable iff (!por_n)
        (cfg_s.clk_sel == CK_GND && !set_a && !clr_a &&
         $past(cfg_s.clk_sel == CK_GND && !set_a && !clr_a)) |-> $stable(q)); // R2
    AST_BLK0_LOAD: assert property (@(posedge blk_clk[0]) disable iff (!por_n)
        (cfg_s.clk_sel == CK_BLK0 && ce && !set_a && !clr_a)
        |=> (q == $past(d) || set_a || clr_a)); // R1
endmodule

// File: tb/tb_mc_reg_cell.sv
`timescale 1ns/1ps
module tb_mc_reg_cell;
    logic       clk = 1'b0;
    logic [3:1] bclk;
    logic       por_n, pt_clk, shared_pt_clk, pt_ce, blk_init, sr_term0, sr_term1, d;
    logic [6:0] cfg;
    logic       q;
    int         tests = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    mc_reg_cell dut (
        .por_n(por_n), .blk_clk({bclk, clk}), .pt_clk(pt_clk),
        .shared_pt_clk(shared_pt_clk), .pt_ce(pt_ce), .blk_init(blk_init),
        .sr_term0(sr_term0), .sr_term1(sr_term1), .d(d), .cfg(cfg), .q(q)
    );

    // cfg = {swap, sr_en, ce_sel[1:0], clk_sel[2:0]}
    typedef struct packed {
        logic [6:0] cfg;
        logic       pce;
        logic       shr;
        logic       dv;
        logic       epor;
        logic       eq;
    } vec_t;

    localparam vec_t VEC [0:12] = '{
        '{7'b0011000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{7'b0011001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{7'b0000010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{7'b0000011, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{7'b0001100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{7'b0001101, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{7'b0011110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{7'b0011111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{7'b1111111, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        '{7'b1111100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{7'b0010000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{7'b0010000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{7'b0111100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: q=%0b expected %0b", tag, act, exp);
        end
    endtask

    // Enter power-on reset with a new configuration; selected clock left low.
    task automatic enter_por(input logic [6:0] c);
        @(negedge clk);
        por_n = 1'b0; cfg = c;
        pt_clk = (c[2:0] == 3'd5); shared_pt_clk = 1'b0; bclk = '0;
        pt_ce = 1'b0; blk_init = 1'b0; sr_term0 = 1'b0; sr_term1 = 1'b0;
        #1;
    endtask

    task automatic release_por();
        @(negedge clk);
        por_n = 1'b1;
    endtask

    // Produce one rising edge on the selected clock, then settle at a negedge.
    task automatic pulse();
        case (cfg[2:0])
            3'd1: begin #1 bclk[1] = 1'b1; #2 bclk[1] = 1'b0; end
            3'd2: begin #1 bclk[2] = 1'b1; #2 bclk[2] = 1'b0; end
            3'd3: begin #1 bclk[3] = 1'b1; #2 bclk[3] = 1'b0; end
            3'd4: begin #1 pt_clk = 1'b1; #2 pt_clk = 1'b0; end
            3'd5: begin #1 pt_clk = 1'b0; #2 pt_clk = 1'b1; end
            3'd6: begin #1 shared_pt_clk = 1'b1; #2 shared_pt_clk = 1'b0; end
            default: ;
        endcase
        @(negedge clk);
        #1;
    endtask

    // Change a term at a negedge and read q before the next edge.
    task automatic drive_terms(input logic t0, input logic t1, input logic bi);
        @(negedge clk);
        sr_term0 = t0; sr_term1 = t1; blk_init = bi;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: q=%0b expected %0b", q, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        por_n = 1'b1; cfg = '0; bclk = '0; pt_clk = 1'b0; shared_pt_clk = 1'b0;
        pt_ce = 1'b0; blk_init = 1'b0; sr_term0 = 1'b0; sr_term1 = 1'b0; d = 1'b0;
        #1 por_n = 1'b0;
        #2;
        chk(q, 1'b0, "R9 reset state");

        // Table: clock sources (R1), enable sources (R3), power-on value (R9).
        for (int i = 0; i <= 12; i++) begin
            enter_por(VEC[i].cfg);
            d = VEC[i].dv;
            chk(q, VEC[i].epor, $sformatf("R9 vec%0d por value", i));
            release_por();
            pt_ce = VEC[i].pce; shared_pt_clk = VEC[i].shr;
            pulse();
            chk(q, VEC[i].eq, $sformatf("R1 R3 vec%0d load", i));
        end

        // R6 / R11 / R8: unswapped roles, async action between edges.
        enter_por(7'b0111100);
        release_por();
        d = 1'b1; pulse();
        chk(q, 1'b1, "R6 preload");
        drive_terms(1, 0, 0); chk(q, 1'b0, "R6 R11 term0 resets");
        drive_terms(0, 1, 0); chk(q, 1'b1, "R6 R11 term1 sets");
        d = 1'b0; pulse();
        chk(q, 1'b1, "R11 set overrides clock and d");
        drive_terms(0, 0, 1); chk(q, 1'b0, "R6 blk_init resets");
        drive_terms(1, 1, 0); chk(q, 1'b0, "R8 both terms");
        drive_terms(0, 1, 0); chk(q, 1'b1, "R6 set after conflict");

        // R7: swapped roles.
        enter_por(7'b1111100);
        chk(q, 1'b1, "R9 swapped por value");
        release_por();
        d = 1'b0; pulse();
        chk(q, 1'b0, "R7 preload");
        drive_terms(1, 0, 0); chk(q, 1'b1, "R7 term0 sets");
        drive_terms(0, 1, 0); chk(q, 1'b0, "R7 term1 resets");
        drive_terms(0, 0, 1); chk(q, 1'b1, "R7 blk_init sets");
        drive_terms(1, 1, 1); chk(q, 1'b0, "R8 swapped conflict");

        // R5: set/reset disabled, terms ignored.
        enter_por(7'b0011100);
        release_por();
        d = 1'b1; pulse();
        drive_terms(1, 0, 1); chk(q, 1'b1, "R5 term0/blk_init ignored");
        d = 1'b0; pulse();
        chk(q, 1'b0, "R5 clock still loads");
        drive_terms(0, 1, 0); chk(q, 1'b0, "R5 term1 ignored");

        // R2: grounded clock.
        enter_por(7'b0111111);
        release_por();
        d = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            cfg[2:0] = 3'd7; // unchanged, kept for clarity
            #1 bclk = '1; pt_clk = 1'b1; shared_pt_clk = 1'b1;
            #1 bclk = '0; pt_clk = 1'b0; shared_pt_clk = 1'b0;
            @(negedge clk);
        end
        #1 chk(q, 1'b0, "R2 ground ignores edges");
        drive_terms(0, 1, 0); chk(q, 1'b1, "R2 async set under ground");
        drive_terms(0, 0, 0);
        d = 1'b0; repeat (3) @(negedge clk);
        #1 chk(q, 1'b1, "R2 holds after set");

        // R4: enable low holds on block clock 0.
        enter_por(7'b0000000);
        release_por();
        pt_ce = 1'b1; d = 1'b1;
        @(negedge clk); #1 chk(q, 1'b1, "R4 enabled load");
        pt_ce = 1'b0; d = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk(q, 1'b1, "R4 enable low holds");

        // R10: terms and clocks ignored during power-on reset.
        enter_por(7'b0111000);
        drive_terms(0, 1, 0);
        d = 1'b1; pt_ce = 1'b1;
        repeat (2) @(negedge clk);
        #1 chk(q, 1'b0, "R10 set term masked by por");
        enter_por(7'b1111000);
        drive_terms(0, 1, 0);
        d = 1'b0;
        repeat (2) @(negedge clk);
        #1 chk(q, 1'b1, "R10 reset term masked by por");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule